// File: doc/BRIEF.md
# Disk Controller Data FIFO

This block is the byte buffer between the host data port of a floppy-style disk controller and the side that feeds or drains the disk serializer. The same storage serves all three command phases. In the command and result phases it behaves as a single holding byte. In the execution phase it is either a one-byte register, which is the legacy behaviour and the state after reset, or a 16-byte FIFO with a programmable service threshold. It produces the request-for-master and direction status bits that pace every host transfer. It also raises a service request that a host interrupt or DMA engine can follow.

The far side port is shared. During the command phase it is where the command decoder takes parameter bytes. During the result phase it is where result bytes are pushed in. During execution it carries one strobe per disk byte time. Every change of phase empties the buffer, so no stale byte survives into a transfer. Errors stop the transfer cleanly:
- An overrun on a disk read freezes the buffer contents for the host to drain.
- An underrun on a disk write fills the rest of the sector with zero bytes and then requests the CRC append.

Top module: `disk_data_fifo`

## Requirements
- R1: After reset the block is in single-byte mode with threshold field 0, and its phase history is the command phase. In the command phase `rqm`=1, `dio`=0 and `svc_req`=0. A reset in the middle of a buffered transfer returns to single-byte mode.
- R2: A `cfg_wr` pulse loads `cfg_buf_en` and `cfg_thresh`. A threshold field of 0 acts as 1. Capacity is 16 bytes only in the execution phase with buffering enabled; in every other case it is one byte.
- R3: `phase` encoding is 00 command, 01 execution, 1x result. `dio`=1 in the result phase and in an execution-phase read (`exec_read`=1), and `dio`=0 otherwise. With `dio`=1, `rqm`=1 exactly when a byte is held. With `dio`=0, `rqm`=1 exactly when there is room and no error is flagged. Host strobes are honoured only while `rqm`=1. `host_rdata` shows the oldest byte.
- R4: In any cycle where `phase` differs from its value in the previous cycle, the buffer and all error and sector state are cleared. `rqm` and `svc_req` are low in that cycle and strobes are ignored.
- R5: During an execution read, `svc_req`=1 when a byte is held and either buffering is off or the free space (16 minus the fill level) is at most the threshold.
- R6: During an execution write, `svc_req`=1 when there is room, no underrun has occurred, and either buffering is off or the fill level is at most the threshold. `svc_req`=0 outside the execution phase.
- R7: An execution-read strobe that arrives when the buffer is full, with no host read in the same cycle, drops that byte and sets `ovr_flag`. Later disk bytes are ignored. The host can still drain the held bytes, and `xfer_end` rises once the buffer is empty.
- R8: An execution-write strobe that arrives when the buffer is empty sets `udr_flag` and blocks host writes. That strobe and every later one up to the end of the sector present `dsk_rdata`=0x00. One cycle after the last byte of the sector, `crc_go` pulses for one cycle and `xfer_end` goes high.
- R9: The sector length is 32 bytes. Sector position is counted from entry to the execution phase, over every execution-write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Load configuration |
| cfg_buf_en | input | 1 | Enable buffered execution mode |
| cfg_thresh | input | 4 | Service threshold, 0 treated as 1 |
| phase | input | 2 | Controller phase: 00 command, 01 execution, 1x result |
| exec_read | input | 1 | Execution direction, 1 = disk to host |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Oldest held byte |
| rqm | output | 1 | Host may transfer a byte |
| dio | output | 1 | Direction, 1 = toward host |
| svc_req | output | 1 | Interrupt/DMA service request |
| dsk_stb | input | 1 | Far-side byte strobe |
| dsk_wdata | input | 8 | Byte entering from far side |
| dsk_rdata | output | 8 | Byte leaving to far side (0x00 when empty or padding) |
| ovr_flag | output | 1 | Overrun occurred |
| udr_flag | output | 1 | Underrun occurred |
| crc_go | output | 1 | Padded sector complete, append CRC |
| xfer_end | output | 1 | Terminated transfer finished |

## Verification
The bench targets the flush at execution entry by writing a command byte and then entering a write. A design that kept the byte would send it to the disk instead of underrunning on the first strobe. Threshold edges are checked at threshold 4, at 8 and at a field of 0. A design with an off-by-one in the free-space or fill comparison would raise `svc_req` one cycle early or late. For overrun, the bench confirms that exactly the 16 held bytes drain in order after the dropped byte; a design that kept accepting disk bytes would deliver more. For a write underrun part-way into the second sector, exactly 27 zero bytes must appear before `crc_go`; a sector counter that is not restarted at execution entry, or that is off by one, would give a different count.

// File: rtl/disk_data_fifo.sv
module disk_data_fifo #(
  parameter int DEPTH        = 16,
  parameter int THR_W        = 4,
  parameter int SECTOR_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_buf_en,
  input  logic [THR_W-1:0] cfg_thresh,
  input  logic [1:0]       phase,
  input  logic             exec_read,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  input  logic             host_rd,
  output logic [7:0]       host_rdata,
  output logic             rqm,
  output logic             dio,
  output logic             svc_req,
  input  logic             dsk_stb,
  input  logic [7:0]       dsk_wdata,
  output logic [7:0]       dsk_rdata,
  output logic             ovr_flag,
  output logic             udr_flag,
  output logic             crc_go,
  output logic             xfer_end
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(SECTOR_BYTES);

  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             buf_en;
  logic [THR_W-1:0] thr;
  logic [1:0]       ph_q;
  logic [SW-1:0]    sec;
  logic             ovr, udr, pdone, crc_q;

  logic in_exec, in_cmd, in_res, ph_chg, to_host, x_wr, x_rd;
  assign in_exec = (phase == 2'b01);
  assign in_cmd  = (phase == 2'b00);
  assign in_res  = phase[1];
  assign ph_chg  = (phase != ph_q);
  assign to_host = in_res | (in_exec & exec_read);
  assign x_wr    = in_exec & ~exec_read;
  assign x_rd    = in_exec & exec_read;

  logic [CW-1:0] cap, thr_eff;
  logic empty, full;
  assign cap     = (in_exec && buf_en) ? CW'(DEPTH) : CW'(1);
  assign thr_eff = (thr == '0) ? CW'(1) : CW'(thr);
  assign empty   = (cnt == '0);
  assign full    = (cnt >= cap);

  assign rqm = ~ph_chg & (to_host ? ~empty : (~full & ~ovr & ~udr));
  assign dio = to_host;

  logic host_pop, host_push, stb, udr_evt, pad_stb, far_pop, far_try, far_push, ovr_evt;
  logic pop, push, pad_last;
  assign stb       = dsk_stb & ~ph_chg;
  assign host_pop  = host_rd & rqm & to_host;
  assign udr_evt   = stb & x_wr & ~udr & empty;
  assign host_push = host_wr & rqm & ~to_host & ~udr_evt;
  assign pad_stb   = stb & x_wr & ((udr & ~pdone) | udr_evt);
  assign far_pop   = stb & ~empty & (in_cmd | (x_wr & ~udr));
  assign far_try   = stb & (in_res | (x_rd & ~ovr));
  assign far_push  = far_try & (~full | host_pop);
  assign ovr_evt   = far_try & x_rd & full & ~host_pop;
  assign pop       = host_pop | far_pop;
  assign push      = host_push | far_push;
  assign pad_last  = pad_stb & (sec == SW'(SECTOR_BYTES - 1));

  assign svc_req = in_exec & ~ph_chg &
                   (exec_read ? (~empty & (~buf_en | ((CW'(DEPTH) - cnt) <= thr_eff)))
                              : (~full & ~udr & (~buf_en | (cnt <= thr_eff))));

  assign host_rdata = mem[rp];
  assign dsk_rdata  = (empty | udr) ? 8'h00 : mem[rp];
  assign ovr_flag   = ovr;
  assign udr_flag   = udr;
  assign crc_go     = crc_q;
  assign xfer_end   = (ovr & empty) | pdone;

  always_ff @(posedge clk) begin
    if (push && !ph_chg) mem[wp] <= host_push ? host_wdata : dsk_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en <= 1'b0;
      thr    <= '0;
    end else if (cfg_wr) begin
      buf_en <= cfg_buf_en;
      thr    <= cfg_thresh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 2'b00;
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      sec   <= '0;
      ovr   <= 1'b0;
      udr   <= 1'b0;
      pdone <= 1'b0;
      crc_q <= 1'b0;
    end else begin
      ph_q <= phase;
      if (ph_chg) begin
        wp    <= '0;
        rp    <= '0;
        cnt   <= '0;
        sec   <= '0;
        ovr   <= 1'b0;
        udr   <= 1'b0;
        pdone <= 1'b0;
        crc_q <= 1'b0;
      end else begin
        if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
        if ((far_pop && x_wr) || pad_stb)
          sec <= (sec == SW'(SECTOR_BYTES - 1)) ? '0 : sec + 1'b1;
        if (udr_evt)  udr   <= 1'b1;
        if (ovr_evt)  ovr   <= 1'b1;
        if (pad_last) pdone <= 1'b1;
        crc_q <= pad_last;
      end
    end
  end
endmodule

module disk_data_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase,
  input logic       exec_read,
  input logic       rqm,
  input logic       dio,
  input logic       svc_req,
  input logic       ovr_flag,
  input logic       udr_flag,
  input logic       crc_go,
  input logic       xfer_end
);
  logic       seen;
  logic [1:0] ph_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      ph_prev <= 2'b00;
    end else begin
      seen    <= 1'b1;
      ph_prev <= phase;
    end
  end

  assert_cmd_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00) |-> !dio);
  assert_flush_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && phase != ph_prev) |-> (!rqm && !svc_req));
  assert_svc_exec_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'b01) |-> !svc_req);
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ovr_flag) |=> (ovr_flag || $past(phase != ph_prev)));
  assert_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && phase == 2'b01 && exec_read) |-> !rqm);
  assert_udr_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_flag && phase == 2'b01 && !exec_read) |-> !rqm);
  assert_crc_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_go |=> !crc_go);
endmodule

bind disk_data_fifo disk_data_fifo_chk chk_i (.*);

// File: tb/disk_data_fifo_tb_top.sv
module disk_data_fifo_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_buf_en = 0;
  logic [3:0] cfg_thresh = 0;
  logic [1:0] phase = 2'b00;
  logic exec_read = 0, host_wr = 0, host_rd = 0, dsk_stb = 0;
  logic [7:0] host_wdata = 0, dsk_wdata = 0;
  logic [7:0] host_rdata, dsk_rdata;
  logic rqm, dio, svc_req, ovr_flag, udr_flag, crc_go, xfer_end;

  always #5 clk = ~clk;

  disk_data_fifo dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  bit [7:0] q[$];
  bit mb, movr, mudr, mpd, mcrc;
  int mt, msec;
  bit [1:0] mphq;

  bit e_rqm, e_dio, e_svc, e_xend;
  bit [7:0] e_dsk;

  task automatic model_out();
    bit ex, chg, toh, full, emp;
    int cap, te;
    ex  = (phase == 2'b01);
    chg = (phase != mphq);
    toh = phase[1] || (ex && exec_read);
    cap = (ex && mb) ? 16 : 1;
    emp = (q.size() == 0);
    full = (q.size() >= cap);
    te  = (mt == 0) ? 1 : mt;
    e_dio = toh;
    e_rqm = !chg && (toh ? !emp : (!full && !movr && !mudr));
    e_svc = ex && !chg && (exec_read ? (!emp && (!mb || (16 - q.size()) <= te))
                                     : (!full && !mudr && (!mb || q.size() <= te)));
    e_dsk = (emp || mudr) ? 8'h00 : q[0];
    e_xend = (movr && emp) || mpd;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); mb = 0; mt = 0; mphq = 2'b00; msec = 0;
      movr = 0; mudr = 0; mpd = 0; mcrc = 0;
    end else begin
      bit ex, xw, xr, emp, full, hp, uevt, hpush, padstb, fpop, ftry, fpush, oevt, last;
      int cap;
      model_out();
      ex = (phase == 2'b01);
      if (phase != mphq) begin
        q.delete(); msec = 0; movr = 0; mudr = 0; mpd = 0; mcrc = 0;
      end else begin
        xw = ex && !exec_read;
        xr = ex && exec_read;
        cap = (ex && mb) ? 16 : 1;
        emp = (q.size() == 0);
        full = (q.size() >= cap);
        hp = host_rd && e_rqm && e_dio;
        uevt = dsk_stb && xw && !mudr && emp;
        hpush = host_wr && e_rqm && !e_dio && !uevt;
        padstb = dsk_stb && xw && ((mudr && !mpd) || uevt);
        fpop = dsk_stb && !emp && (phase == 2'b00 || (xw && !mudr));
        ftry = dsk_stb && (phase[1] || (xr && !movr));
        fpush = ftry && (!full || hp);
        oevt = ftry && xr && full && !hp;
        last = padstb && (msec == 31);
        if (hp || fpop) void'(q.pop_front());
        if (hpush) q.push_back(host_wdata);
        if (fpush) q.push_back(dsk_wdata);
        if ((fpop && xw) || padstb) msec = (msec == 31) ? 0 : msec + 1;
        if (uevt) mudr = 1;
        if (oevt) movr = 1;
        if (last) mpd = 1;
        mcrc = last;
      end
      if (cfg_wr) begin mb = cfg_buf_en; mt = cfg_thresh; end
      mphq = phase;
    end
  end

  task automatic chk(string what, string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    model_out();
    chk("rqm", "R3", rqm, e_rqm);
    chk("dio", "R3", dio, e_dio);
    chk("svc_req", exec_read ? "R5" : "R6", svc_req, e_svc);
    chk("dsk_rdata", "R8", dsk_rdata, e_dsk);
    chk("ovr_flag", "R7", ovr_flag, movr);
    chk("udr_flag", "R8", udr_flag, mudr);
    chk("crc_go", "R8", crc_go, mcrc);
    chk("xfer_end", "R7", xfer_end, e_xend);
    if (q.size() != 0) chk("host_rdata", "R3", host_rdata, q[0]);
  endtask

  bit [7:0] obs_dsk, obs_hrd;
  bit obs_stb, obs_hpop;

  task automatic cyc();
    #3;
    compare_all();
    obs_dsk = dsk_rdata; obs_stb = dsk_stb;
    obs_hrd = host_rdata; obs_hpop = host_rd && rqm;
    @(posedge clk);
    #1;
    host_wr = 0; host_rd = 0; dsk_stb = 0; cfg_wr = 0;
  endtask

  task automatic configure(bit en, int t);
    cfg_wr = 1; cfg_buf_en = en; cfg_thresh = 4'(t);
    cyc();
  endtask

  task automatic enter(bit rd);
    phase = 2'b00; cyc();
    phase = 2'b01; exec_read = rd; cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired (all requirements)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int sent, consumed, zeros, gen, rcv, drained;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("reset rqm", "R1", rqm, 1);
    chk("reset dio", "R1", dio, 0);
    chk("reset svc", "R1", svc_req, 0);

    // R3: command byte handed to the decoder side
    host_wr = 1; host_wdata = 8'h5A; cyc();
    chk("rqm after param byte", "R3", rqm, 0);
    dsk_stb = 1; #1; chk("param byte to decoder", "R3", dsk_rdata, 8'h5A); cyc();
    chk("rqm after take", "R3", rqm, 1);

    // R4: held command byte is flushed at execution entry
    host_wr = 1; host_wdata = 8'h33; cyc();
    phase = 2'b01; exec_read = 0; #1;
    chk("rqm on entry cycle", "R4", rqm, 0);
    cyc();
    dsk_stb = 1; #1; chk("flushed byte not sent", "R4", dsk_rdata, 8'h00); cyc();
    chk("underrun after flush", "R4", udr_flag, 1);
    zeros = 1;
    for (int k = 0; k < 200 && !crc_go; k++) begin
      dsk_stb = (k % 3 == 0); cyc();
      if (obs_stb && obs_dsk == 0) zeros++;
    end
    chk("pad count from sector start", "R8", zeros, 32);
    chk("xfer_end after pad", "R8", xfer_end, 1);

    // R2, R6, R8, R9: buffered write, underrun in second sector
    configure(1, 4);
    enter(0);
    sent = 0;
    for (int k = 0; k < 20; k++) begin
      #1; if (rqm) begin host_wr = 1; host_wdata = 8'h80 | 8'(sent); sent++; end
      cyc();
    end
    chk("buffered capacity", "R2", sent, 16);
    consumed = 0; zeros = 0;
    for (int k = 0; k < 800 && !crc_go; k++) begin
      dsk_stb = (k % 4 == 0);
      #1; if (svc_req && rqm && sent < 37) begin host_wr = 1; host_wdata = 8'h80 | 8'(sent); sent++; end
      cyc();
      if (obs_stb) begin
        if (obs_dsk != 0) begin
          chk("write byte order", "R6", obs_dsk, 8'h80 | 8'(consumed)); consumed++;
        end else zeros++;
      end
    end
    chk("bytes written to disk", "R9", consumed, 37);
    chk("zero pad count", "R8", zeros, 27);
    chk("xfer_end after crc", "R8", xfer_end, 1);

    // R5, R7: buffered read with overrun and drain
    configure(1, 8);
    enter(1);
    gen = 1; rcv = 0;
    for (int k = 0; k < 140; k++) begin
      dsk_stb = (k % 2 == 0); dsk_wdata = 8'(gen);
      #1; if (svc_req && k < 60) host_rd = 1;
      if (dsk_stb) gen++;
      cyc();
      if (obs_hpop) begin rcv++; chk("read byte order", "R5", obs_hrd, 8'(rcv)); end
    end
    chk("overrun flag", "R7", ovr_flag, 1);
    drained = 0;
    for (int k = 0; k < 30; k++) begin
      dsk_stb = 1; dsk_wdata = 8'hEE;
      #1; if (rqm) host_rd = 1;
      cyc();
      if (obs_hpop) begin rcv++; drained++; chk("drain order", "R7", obs_hrd, 8'(rcv)); end
    end
    chk("drained count", "R7", drained, 16);
    chk("xfer_end after drain", "R7", xfer_end, 1);

    // R7, R3: single-byte read overrun
    configure(0, 4);
    enter(1);
    dsk_stb = 1; dsk_wdata = 8'h11; cyc();
    chk("single byte ready", "R3", rqm, 1);
    chk("single byte data", "R3", host_rdata, 8'h11);
    dsk_stb = 1; dsk_wdata = 8'h22; cyc();
    chk("single byte overrun", "R7", ovr_flag, 1);
    host_rd = 1; cyc();
    chk("kept first byte", "R7", obs_hrd, 8'h11);
    chk("end after single drain", "R7", xfer_end, 1);

    // R3: result phase
    phase = 2'b10; cyc();
    chk("result dio", "R3", dio, 1);
    chk("result empty rqm", "R3", rqm, 0);
    dsk_stb = 1; dsk_wdata = 8'h77; cyc();
    chk("result rqm", "R3", rqm, 1);
    host_rd = 1; cyc();
    chk("result byte", "R3", obs_hrd, 8'h77);

    // R2, R6: threshold field 0 acts as 1
    configure(1, 0);
    enter(0);
    for (int k = 0; k < 3; k++) begin host_wr = 1; host_wdata = 8'h90 | 8'(k); cyc(); end
    #1; chk("svc above thr 1", "R6", svc_req, 0);
    dsk_stb = 1; cyc();
    #1; chk("svc at fill 2", "R6", svc_req, 0);
    dsk_stb = 1; cyc();
    #1; chk("svc at fill 1", "R6", svc_req, 1);

    // R1: reset mid-transfer drops buffered mode
    rst_n = 0; #2; rst_n = 1;
    phase = 2'b01; exec_read = 0; cyc();
    host_wr = 1; host_wdata = 8'h44; cyc();
    #1; chk("single byte after reset", "R1", rqm, 0);
    cyc(); cyc();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule